// File: doc/BRIEF.md
# Instruction Fill Predecoder

This block sits on the path that fills the instruction cache. It takes one 8-byte beat of instruction bytes per cycle. To every byte it attaches five marker bits, so each stored byte becomes a 13-bit lane. The markers show:
- where each variable-length instruction begins and ends;
- which byte is the opcode;
- how many internal operations the decoder must issue for the instruction, from one to four.

With these markers, a decode stage fed from a cache hit can split instructions without running the length search again.

Instructions are not aligned to beats. A parse that is still open at the last lane is held in a small carry register, and the next valid beat continues from it. A restart request says at which lane a new instruction begins. It discards the carried parse, for example after a redirected fetch. When no beat is present, a restart on its own simply clears the carry.

The length rule is a reduced variable-length format:
- optional prefix bytes;
- one opcode byte;
- an optional register/memory selector byte, possibly followed by a scale-index byte;
- a displacement;
- an immediate.

Top module: `ifill_predecode`

## Requirements
- R1: After reset, `out_vld` is 0 and `out_lanes` is all zero. The first valid beat is parsed as a new instruction starting at lane 0.
- R2: Lane i of `in_bytes` is bits [8i+7:8i], and lane 0 is earliest in program order. One cycle after a beat with `in_vld`=1, `out_vld`=1. Lane i of `out_lanes` (bits [13i+12:13i]) then holds:
  - bits [7:0]: the input byte, unchanged;
  - bit 8: start;
  - bit 9: end;
  - bit 10: opcode;
  - bits [12:11]: operation count minus one.
- R3: Bytes 0xF0 to 0xF3 seen before the opcode are prefixes. A prefix is never flagged as an opcode. The start bit is set only on the first byte of an instruction, whether that byte is a prefix or the opcode.
- R4: An opcode with bit 7 = 1 has no selector byte. Opcode bits [1:0] set the number of immediate bytes that follow: 00 gives 0, 01 gives 1, 10 gives 2, 11 gives 4.
- R5: An opcode with bit 7 = 0 is followed by a selector byte (mode in bits [7:6], base in bits [2:0]). Next come:
  - a scale-index byte, when mode is not 11 and base is 100;
  - displacement bytes: 1 for mode 01, 4 for mode 10, 4 for mode 00 with base 101, otherwise 0;
  - the immediate given by opcode bits [1:0], as in R4.
- R6: The operation count is written only on the end byte and is 0 on every other byte. The count is:
  - 1 (field 00) without a selector byte, or when the mode is 11;
  - 2 (field 01) for a memory mode with opcode bit 2 = 0;
  - 4 (field 11) for a memory mode with opcode bit 2 = 1.
- R7: An instruction that crosses a beat boundary keeps its parse. Its remaining bytes in the next valid beat get the same markers they would get if the bytes were contiguous.
- R8: The sixteenth byte of an unfinished instruction gets the invalid pattern 11111 in bits [12:8]. The byte after it begins a new instruction.
- R9: A restart with `in_vld`=1 and offset k discards the carried parse. Lanes below k get all-zero markers, and lane k begins a new instruction.
- R10: A restart with `in_vld`=0 discards the carried parse. The next valid beat begins a new instruction at lane 0.
- R11: A cycle with `in_vld`=0 and no restart leaves the carried parse unchanged, and `out_vld` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | A fill beat is present on `in_bytes` |
| in_bytes | input | 64 | Eight instruction bytes, lane 0 in the low byte |
| rs_req | input | 1 | Restart: drop the carried parse |
| rs_off | input | 3 | Lane where the new instruction begins when `rs_req` comes with a beat |
| out_vld | output | 1 | Annotated beat valid |
| out_lanes | output | 104 | Eight 13-bit lanes, each a byte with its five marker bits |

## Verification
The interesting collision is a restart landing in a beat that still owes bytes to an instruction carried from the previous beat. It is also tried at offset 0, in the middle and at the last lane. The bench drives such beats on purpose. It also drives them at random, mixed with idle gaps and bare flushes. A second collision is the sixteen-byte limit meeting a beat boundary or falling inside the displacement bytes. Long prefix runs and prefixed long-displacement forms provoke it. Every cycle, a behavioural byte-serial model predicts `out_vld` and all lanes, and the bench compares the whole beat against it.

// File: rtl/ifill_pd_pkg.sv
package ifill_pd_pkg;

   localparam int BYTE_W = 8;
   localparam int MARK_W = 5;
   localparam int LANE_W = BYTE_W + MARK_W;
   localparam int LEN_W  = 4;
   localparam int OWE_W  = 4;

   typedef enum logic [1:0] {
      PH_HEAD  = 2'd0,
      PH_MODRM = 2'd1,
      PH_SIB   = 2'd2,
      PH_TAIL  = 2'd3
   } ph_t;

   // Parse state handed from byte to byte and from beat to beat.
   typedef struct packed {
      ph_t              ph;
      logic [LEN_W-1:0] len;   // bytes already consumed by this instruction
      logic [OWE_W-1:0] owe;   // bytes still owed after the current field
      logic             kind;  // opcode bit 2: memory form writes back
      logic [1:0]       ops;   // operation count minus one
   } pd_state_t;

   // Marker bits as stored above the byte: {cnt, opc, fin, beg}.
   typedef struct packed {
      logic [1:0] cnt;
      logic       opc;
      logic       fin;
      logic       beg;
   } pd_mark_t;

   localparam pd_state_t ST_IDLE = '{ph: PH_HEAD, len: '0, owe: '0, kind: 1'b0, ops: 2'd0};
   localparam pd_mark_t  MK_BAD  = '{cnt: 2'd3, opc: 1'b1, fin: 1'b1, beg: 1'b1};

   function automatic logic is_prefix(input logic [BYTE_W-1:0] b);
      return b[7:2] == 6'b111100;
   endfunction

   function automatic logic [OWE_W-1:0] imm_bytes(input logic [1:0] code);
      unique case (code)
         2'd0: return OWE_W'(0);
         2'd1: return OWE_W'(1);
         2'd2: return OWE_W'(2);
         default: return OWE_W'(4);
      endcase
   endfunction

   function automatic logic [OWE_W-1:0] disp_bytes(input logic [1:0] mode, input logic [2:0] base);
      if (mode == 2'd1)                      return OWE_W'(1);
      else if (mode == 2'd2)                 return OWE_W'(4);
      else if (mode == 2'd0 && base == 3'd5) return OWE_W'(4);
      else                                   return OWE_W'(0);
   endfunction

endpackage

// File: rtl/predec_step.sv
module predec_step
   import ifill_pd_pkg::*;
#(
   parameter int MAX_LEN = 15
) (
   input  pd_state_t          st_i,
   input  logic [BYTE_W-1:0]  byte_i,
   input  logic               act_i,
   output pd_state_t          st_o,
   output pd_mark_t           mk_o
);

   logic             done;
   logic [OWE_W-1:0] tot;
   logic [1:0]       mode;
   logic [2:0]       base;

   assign mode = byte_i[7:6];
   assign base = byte_i[2:0];

   always_comb begin
      st_o = st_i;
      mk_o = '0;
      done = 1'b0;
      tot  = '0;
      if (!act_i) begin
         st_o = ST_IDLE;
      end else if (st_i.len == LEN_W'(MAX_LEN)) begin
         mk_o = MK_BAD;
         st_o = ST_IDLE;
      end else begin
         mk_o.beg = (st_i.ph == PH_HEAD) && (st_i.len == '0);
         st_o.len = st_i.len + 1'b1;
         unique case (st_i.ph)
            PH_HEAD: begin
               if (!is_prefix(byte_i)) begin
                  mk_o.opc  = 1'b1;
                  st_o.kind = byte_i[2];
                  st_o.owe  = imm_bytes(byte_i[1:0]);
                  st_o.ops  = 2'd0;
                  if (!byte_i[7])                       st_o.ph = PH_MODRM;
                  else if (imm_bytes(byte_i[1:0]) == '0) done   = 1'b1;
                  else                                  st_o.ph = PH_TAIL;
               end
            end
            PH_MODRM: begin
               tot      = st_i.owe + disp_bytes(mode, base);
               st_o.owe = tot;
               st_o.ops = (mode == 2'd3) ? 2'd0 : (st_i.kind ? 2'd3 : 2'd1);
               if (mode != 2'd3 && base == 3'd4) st_o.ph = PH_SIB;
               else if (tot == '0)               done    = 1'b1;
               else                              st_o.ph = PH_TAIL;
            end
            PH_SIB: begin
               if (st_i.owe == '0) done    = 1'b1;
               else                st_o.ph = PH_TAIL;
            end
            PH_TAIL: begin
               st_o.owe = st_i.owe - 1'b1;
               if (st_i.owe == OWE_W'(1)) done = 1'b1;
            end
         endcase
         if (done) begin
            mk_o.fin = 1'b1;
            mk_o.cnt = st_o.ops;
            st_o     = ST_IDLE;
         end
      end
   end

endmodule

// File: rtl/predec_carry.sv
module predec_carry
   import ifill_pd_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      in_vld,
   input  logic      rs_req,
   input  pd_state_t nxt_i,
   output pd_state_t cur_o
);

   always_ff @(posedge clk) begin
      if (rst)         cur_o <= ST_IDLE;
      else if (in_vld) cur_o <= nxt_i;
      else if (rs_req) cur_o <= ST_IDLE;
   end

   p_flush_idle_r10: assert property (@(posedge clk) disable iff (rst)
      (rs_req && !in_vld) |=> (cur_o == ST_IDLE));

   p_hold_idle_r11: assert property (@(posedge clk) disable iff (rst)
      (!rs_req && !in_vld) |=> $stable(cur_o));

   p_tail_owes_r7: assert property (@(posedge clk) disable iff (rst)
      (cur_o.ph == PH_TAIL) |-> (cur_o.owe != '0));

endmodule

// File: rtl/ifill_predecode.sv
module ifill_predecode
   import ifill_pd_pkg::*;
#(
   parameter int LANES   = 8,
   parameter int MAX_LEN = 15,
   parameter bit REG_OUT = 1'b1,
   localparam int OFF_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      in_vld,
   input  logic [LANES*BYTE_W-1:0]   in_bytes,
   input  logic                      rs_req,
   input  logic [OFF_W-1:0]          rs_off,
   output logic                      out_vld,
   output logic [LANES*LANE_W-1:0]   out_lanes
);

   if (LANES < 1) begin : g_bad_lanes
      $error("ifill_predecode: LANES must be at least 1");
   end
   if (MAX_LEN < 2 || MAX_LEN >= (1 << LEN_W)) begin : g_bad_len
      $error("ifill_predecode: MAX_LEN must fit the length counter");
   end

   pd_state_t                  chain [LANES+1];
   pd_state_t                  carry;
   pd_mark_t                   mk    [LANES];
   logic                       act   [LANES];
   logic [LANES*LANE_W-1:0]    lane_d;

   assign chain[0] = rs_req ? ST_IDLE : carry;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign act[i] = !(rs_req && (int'(rs_off) > i));
      predec_step #(.MAX_LEN(MAX_LEN)) u_step (
         .st_i   (chain[i]),
         .byte_i (in_bytes[i*BYTE_W +: BYTE_W]),
         .act_i  (act[i]),
         .st_o   (chain[i+1]),
         .mk_o   (mk[i])
      );
      assign lane_d[i*LANE_W +: LANE_W] = {mk[i], in_bytes[i*BYTE_W +: BYTE_W]};
   end

   predec_carry u_carry (
      .clk    (clk),
      .rst    (rst),
      .in_vld (in_vld),
      .rs_req (rs_req),
      .nxt_i  (chain[LANES]),
      .cur_o  (carry)
   );

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk) begin
         if (rst) begin
            out_vld   <= 1'b0;
            out_lanes <= '0;
         end else begin
            out_vld <= in_vld;
            if (in_vld) out_lanes <= lane_d;
         end
      end

      p_out_follows_r2: assert property (@(posedge clk) disable iff (rst)
         in_vld |=> out_vld);

      p_out_quiet_r11: assert property (@(posedge clk) disable iff (rst)
         !in_vld |=> !out_vld);

      for (genvar i = 0; i < LANES; i++) begin : g_chk
         p_low_lanes_r9: assert property (@(posedge clk) disable iff (rst)
            (in_vld && rs_req && (int'(rs_off) > i))
               |=> (out_lanes[i*LANE_W+BYTE_W +: MARK_W] == '0));

         p_cnt_on_end_r6: assert property (@(posedge clk) disable iff (rst)
            (out_vld && !out_lanes[i*LANE_W+BYTE_W+1])
               |-> (out_lanes[i*LANE_W+BYTE_W+3 +: 2] == 2'b00));
      end
   end else begin : g_comb_out
      assign out_vld   = in_vld;
      assign out_lanes = lane_d;
   end

endmodule

// File: tb/ifill_predecode_bench.sv
module ifill_predecode_bench;

   localparam int LANES = 8;
   localparam int LW    = 13;

   logic                  clk = 1'b0;
   logic                  rst = 1'b1;
   logic                  in_vld = 1'b0;
   logic [LANES*8-1:0]    in_bytes = '0;
   logic                  rs_req = 1'b0;
   logic [2:0]            rs_off = '0;
   logic                  out_vld;
   logic [LANES*LW-1:0]   out_lanes;

   always #10 clk = ~clk;

   ifill_predecode u_ifill_predecode (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_bytes(in_bytes),
      .rs_req(rs_req), .rs_off(rs_off), .out_vld(out_vld), .out_lanes(out_lanes)
   );

   int    n_chk = 0;
   int    n_fail = 0;
   string cur_req = "R1";

   // behavioural reference state
   int m_ph = 0, m_len = 0, m_owe = 0, m_kind = 0, m_ops = 0;
   logic                exp_vld = 1'b0;
   logic [LANES*LW-1:0] exp_lanes = '0;
   logic [7:0]          q[$];

   task automatic model_idle();
      m_ph = 0; m_len = 0; m_owe = 0; m_kind = 0; m_ops = 0;
   endtask

   task automatic model_byte(input logic [7:0] b, output logic [4:0] mk);
      logic st, op, fin;
      int   mode, base, dsp, imm;
      if (m_len == 15) begin
         mk = 5'b11111;
         model_idle();
         return;
      end
      st = (m_ph == 0 && m_len == 0);
      op = 1'b0; fin = 1'b0;
      m_len++;
      case (m_ph)
         0: if (b[7:2] != 6'b111100) begin
               op = 1'b1;
               m_kind = b[2];
               imm = (b[1:0] == 2'd3) ? 4 : int'(b[1:0]);
               m_owe = imm; m_ops = 0;
               if (!b[7]) m_ph = 1;
               else if (imm == 0) fin = 1'b1;
               else m_ph = 3;
            end
         1: begin
               mode = int'(b[7:6]); base = int'(b[2:0]);
               dsp = (mode == 1) ? 1 : (mode == 2) ? 4 : (mode == 0 && base == 5) ? 4 : 0;
               m_ops = (mode == 3) ? 0 : (m_kind != 0 ? 3 : 1);
               m_owe = m_owe + dsp;
               if (mode != 3 && base == 4) m_ph = 2;
               else if (m_owe == 0) fin = 1'b1;
               else m_ph = 3;
            end
         2: if (m_owe == 0) fin = 1'b1; else m_ph = 3;
         default: begin
               m_owe--;
               if (m_owe == 0) fin = 1'b1;
            end
      endcase
      mk = {fin ? 2'(m_ops) : 2'b00, op, fin, st};
      if (fin) model_idle();
   endtask

   task automatic model_beat(input logic v, input logic rs, input int off, input logic [63:0] d);
      logic [4:0] mk;
      if (!v) begin
         if (rs) model_idle();
         exp_vld = 1'b0;
         return;
      end
      if (rs) model_idle();
      exp_vld = 1'b1;
      for (int i = 0; i < LANES; i++) begin
         if (rs && i < off) mk = 5'b0;
         else model_byte(d[8*i +: 8], mk);
         exp_lanes[LW*i +: LW] = {mk, d[8*i +: 8]};
      end
   endtask

   task automatic check_now();
      n_chk++;
      if (out_vld !== exp_vld || (exp_vld && out_lanes !== exp_lanes)) begin
         n_fail++;
         $display("FAIL %s: got vld %b lanes %h, expected vld %b lanes %h",
                  cur_req, out_vld, out_lanes, exp_vld, exp_lanes);
      end
   endtask

   // one clock: judge the previous beat, then present the next one
   task automatic step(input logic v, input logic rs, input int off, input logic [63:0] d);
      @(negedge clk);
      check_now();
      model_beat(v, rs, off, d);
      in_vld = v; rs_req = rs; rs_off = 3'(off); in_bytes = d;
   endtask

   task automatic send_beat_q(input logic rs, input int off);
      logic [63:0] d;
      for (int i = 0; i < LANES; i++)
         d[8*i +: 8] = (q.size() > 0) ? q.pop_front() : 8'h80;
      step(1'b1, rs, off, d);
   endtask

   task automatic send_q(input int gap);
      while (q.size() > 0) begin
         send_beat_q(1'b0, 0);
         if (gap != 0) step(1'b0, 1'b0, 0, '0);
      end
   endtask

   task automatic push(input logic [7:0] b);
      q.push_back(b);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      #(20 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1: reset state seen at the ports
      n_chk++;
      if (out_vld !== 1'b0 || out_lanes !== '0) begin
         n_fail++;
         $display("FAIL R1: got vld %b lanes %h, expected 0 and 0", out_vld, out_lanes);
      end

      // R1 / R2: first beat opens at lane 0
      cur_req = "R1";
      push(8'h80); push(8'h81); push(8'h05); push(8'h82); push(8'h11); push(8'h22);
      push(8'h80); push(8'h80);
      send_q(0);

      // R4: immediate sizes 0, 1, 2, 4
      cur_req = "R4";
      push(8'h83); push(8'hAA); push(8'hBB); push(8'hCC); push(8'hDD);
      push(8'h81); push(8'h7F); push(8'h80); push(8'h82); push(8'h01); push(8'h02);
      push(8'h80); push(8'h80); push(8'h80); push(8'h80); push(8'h80);
      send_q(0);

      // R3: prefixes ahead of opcode
      cur_req = "R3";
      push(8'hF0); push(8'hF2); push(8'h80); push(8'hF3); push(8'h81); push(8'h07);
      push(8'hF1); push(8'hF1); push(8'hF1); push(8'h00); push(8'hC3);
      send_q(0);

      // R5 / R6: selector forms, scale-index, displacement, counts
      cur_req = "R5";
      push(8'h00); push(8'hC0);                                   // reg form, 1 op
      push(8'h04); push(8'h44); push(8'h25); push(8'h10);         // sib + disp8, 4 ops
      push(8'h01); push(8'h05); push(8'h11); push(8'h22); push(8'h33); push(8'h44); push(8'h55);
      push(8'h00); push(8'h01);                                   // mode 00 no disp, 2 ops
      send_q(0);
      cur_req = "R6";
      push(8'h06); push(8'h84); push(8'h00); push(8'h01); push(8'h02); push(8'h03); push(8'h04);
      push(8'h05); push(8'h06);                                   // sib disp4 imm2, 4 ops
      push(8'h07); push(8'hD8); push(8'h01); push(8'h02); push(8'h03); push(8'h04);
      send_q(0);

      // R7: long instruction across beats, with and without idle gaps (R11)
      cur_req = "R7";
      push(8'h80); push(8'h80); push(8'h80); push(8'h80); push(8'h80);
      push(8'h03); push(8'h80); push(8'h11); push(8'h22); push(8'h33); push(8'h44);
      push(8'h55); push(8'h66); push(8'h77); push(8'h88);
      send_q(0);
      cur_req = "R11";
      push(8'h80); push(8'h80); push(8'h80); push(8'h80); push(8'h80); push(8'h80);
      push(8'h07); push(8'h80); push(8'h11); push(8'h22); push(8'h33); push(8'h44);
      push(8'h55); push(8'h66); push(8'h77); push(8'h88);
      send_q(1);
      step(1'b0, 1'b0, 0, '0);
      step(1'b0, 1'b0, 0, '0);

      // R8: sixteen-byte limit on prefix run and inside a displacement
      cur_req = "R8";
      for (int i = 0; i < 17; i++) push(8'hF0);
      push(8'h80);
      send_q(0);
      for (int i = 0; i < 10; i++) push(8'hF1);
      push(8'h03); push(8'h80); push(8'h11); push(8'h22); push(8'h33); push(8'h44);
      push(8'h80); push(8'h80);
      send_q(0);

      // R9: restart while a parse is carried, offsets 3, 0, 7
      cur_req = "R9";
      push(8'h80); push(8'h80); push(8'h80); push(8'h03); push(8'h80); push(8'h11);
      push(8'h22); push(8'h33);
      send_beat_q(1'b0, 0);
      push(8'hAA); push(8'hBB); push(8'hCC); push(8'h81); push(8'h07); push(8'h00);
      push(8'hC1); push(8'h80);
      send_beat_q(1'b1, 3);
      push(8'h80); push(8'h80); push(8'h80); push(8'h80); push(8'h80); push(8'h80);
      push(8'h80); push(8'h03);
      send_beat_q(1'b0, 0);
      push(8'h80); push(8'h81); push(8'h00); push(8'h80); push(8'h80); push(8'h80);
      push(8'h80); push(8'h80);
      send_beat_q(1'b1, 0);
      push(8'h03); push(8'h80); push(8'h80); push(8'h80); push(8'h80); push(8'h80);
      push(8'h80); push(8'h03);
      send_beat_q(1'b0, 0);
      push(8'h01); push(8'h02); push(8'h03); push(8'h04); push(8'h05); push(8'h06);
      push(8'h07); push(8'h83);
      send_beat_q(1'b1, 7);
      push(8'h01); push(8'h02); push(8'h03); push(8'h04); push(8'h80); push(8'h80);
      push(8'h80); push(8'h80);
      send_beat_q(1'b0, 0);

      // R10: bare flush in the middle of an instruction
      cur_req = "R10";
      push(8'h80); push(8'h80); push(8'h80); push(8'h80); push(8'h80); push(8'h80);
      push(8'h03); push(8'h80);
      send_beat_q(1'b0, 0);
      step(1'b0, 1'b1, 5, '0);
      push(8'h80); push(8'h82); push(8'h01); push(8'h02); push(8'h00); push(8'hC7);
      push(8'h80); push(8'h80);
      send_beat_q(1'b0, 0);

      // R2: random streams mixing prefixes, restarts, flushes and gaps
      cur_req = "R2";
      for (int n = 0; n < 400; n++) begin
         logic [63:0] d;
         logic        v, rs;
         for (int i = 0; i < LANES; i++)
            d[8*i +: 8] = ($urandom % 6 == 0) ? (8'hF0 | 8'($urandom % 4)) : 8'($urandom);
         v  = ($urandom % 6) != 0;
         rs = ($urandom % 8) == 0;
         step(v, rs, int'($urandom % 8), d);
      end
      step(1'b0, 1'b0, 0, '0);
      step(1'b0, 1'b0, 0, '0);

      summary();
      $finish;
   end

endmodule